// File: doc/BRIEF.md
# Dual Quad-SPI Flash Lane Router

This block sits between one quad-SPI serial engine and two flash devices that share the engine's single chip select. It takes the engine's serial clock, chip select, four output lanes, their output enables and a byte-wide transfer stream. From these it drives a chip select, a clock and four lanes for a lower device and an upper device. It also returns read data to the engine, both as four lanes and as a reassembled byte.

A three-field configuration word selects how the two devices are used. With the two-device field clear, only the lower device is used. With two devices and no separate buses, the devices are stacked. They share the lanes and clock, and a page field picks which one sees the chip select. With two devices on separate buses, the devices run in parallel. Both are selected at once, and each byte is split bitwise: the even bits go to the lower device and the odd bits go to the upper device. A configuration write can arrive at any time. It takes effect only while the chip select is high, so a transfer that has started is never reconfigured part way through.

Top module: `qspi_dual_router`

## Requirements
- R1: After reset the configuration is all zero. The lower device is then selected alone in single-device mode. If the two-device field (bit 30) is then set with the page field (bit 28) still 0, the lower device is the one selected.
- R2: With bit 30 clear, only the lower device follows the engine chip select. In this mode the upper select stays high, the upper clock stays low and the upper output enables stay 0. Bits 29 and 28 have no effect.
- R3: With bit 30 set and the separate-bus field (bit 29) clear, the engine lanes drive both devices' lanes and exactly one device select follows the engine chip select. A page bit 28 of 0 picks the lower device and 1 picks the upper device.
- R4: In stacked mode the output enables of the device that is not selected are 0.
- R5: With bits 30 and 29 both set, both device selects follow the engine chip select together and both clocks run. Bit 28 has no effect.
- R6: In parallel mode the byte stream is split onto the lanes. Lower lanes [3:0] carry byte bits {6,4,2,0} and upper lanes [3:0] carry bits {7,5,3,1}.
- R7: In parallel mode the returned byte is rebuilt from the device lanes. Bit 2i comes from lower lane i and bit 2i+1 comes from upper lane i. Outside parallel mode the returned byte is 0.
- R8: The engine's four-lane read input comes from the selected device in single and stacked modes, and from the lower device in parallel mode.
- R9: Each device clock equals the engine clock while that device's select is low, and is low otherwise.
- R10: A configuration write made while the engine chip select is low does not change the routing until the chip select has been high at a clock edge.
- R11: While the engine chip select is high, both devices' output enables are 0 and both selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the configuration register |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word (bits 30, 29, 28 used) |
| eng_sclk | input | 1 | Engine serial clock |
| eng_cs_n | input | 1 | Engine chip select, active low |
| eng_dout | input | 4 | Engine output lanes |
| eng_doe | input | 4 | Engine output enables per lane |
| eng_byte_out | input | 8 | Byte to split in parallel mode |
| eng_din | output | 4 | Read lanes returned to the engine |
| eng_byte_in | output | 8 | Byte rebuilt in parallel mode |
| lo_cs_n | output | 1 | Lower device select |
| lo_sclk | output | 1 | Lower device clock |
| lo_dout | output | 4 | Lower device output lanes |
| lo_doe | output | 4 | Lower device output enables |
| lo_din | input | 4 | Lower device read lanes |
| hi_cs_n | output | 1 | Upper device select |
| hi_sclk | output | 1 | Upper device clock |
| hi_dout | output | 4 | Upper device output lanes |
| hi_doe | output | 4 | Upper device output enables |
| hi_din | input | 4 | Upper device read lanes |

## Verification
The in-module properties are checked at every system clock. They cover the invariants of the select lines: exclusive selects when stacked, matched selects in parallel, and an upper device held idle in single mode. They also check that each clock is gated by its own select, that idle or deselected devices have their enables low, and that the active configuration is frozen while the chip select is low. The bit-level routing can only be shown by the bench's scenarios with known bytes and lane patterns. These cover the byte split and reassembly order, the read-lane source in each mode, and the fact that ignored fields really have no effect. The same holds for the reset default and for a write deferred across a live transfer.

// File: rtl/qspi_dual_router.sv
module qspi_dual_router #(
  parameter int CFG_W       = 32,
  parameter int TWO_DEV_BIT = 30,
  parameter int SEP_BUS_BIT = 29,
  parameter int PAGE_BIT    = 28,
  parameter int LANES       = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               eng_sclk,
  input  logic               eng_cs_n,
  input  logic [LANES-1:0]   eng_dout,
  input  logic [LANES-1:0]   eng_doe,
  input  logic [2*LANES-1:0] eng_byte_out,
  output logic [LANES-1:0]   eng_din,
  output logic [2*LANES-1:0] eng_byte_in,
  output logic               lo_cs_n,
  output logic               lo_sclk,
  output logic [LANES-1:0]   lo_dout,
  output logic [LANES-1:0]   lo_doe,
  input  logic [LANES-1:0]   lo_din,
  output logic               hi_cs_n,
  output logic               hi_sclk,
  output logic [LANES-1:0]   hi_dout,
  output logic [LANES-1:0]   hi_doe,
  input  logic [LANES-1:0]   hi_din
);
  localparam int WORD_W = 2 * LANES;

  logic [2:0] wr_fields, pend_q, act_q;
  logic unused_cfg = ^cfg_wdata;

  assign wr_fields = {cfg_wdata[TWO_DEV_BIT], cfg_wdata[SEP_BUS_BIT], cfg_wdata[PAGE_BIT]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 3'b000;
      act_q  <= 3'b000;
    end else begin
      if (cfg_wr) pend_q <= wr_fields;
      if (eng_cs_n) act_q <= cfg_wr ? wr_fields : pend_q;
    end
  end

  logic two_dev, sep_bus, page_up, par_mode, lo_sel, hi_sel;
  assign two_dev  = act_q[2];
  assign sep_bus  = act_q[1];
  assign page_up  = act_q[0];
  assign par_mode = two_dev & sep_bus;
  assign lo_sel   = ~two_dev | sep_bus | ~page_up;
  assign hi_sel   = two_dev & (sep_bus | page_up);

  logic [LANES-1:0]  lo_split, hi_split;
  logic [WORD_W-1:0] merged;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lo_split[i]     = eng_byte_out[2*i];
    assign hi_split[i]     = eng_byte_out[2*i+1];
    assign merged[2*i]     = lo_din[i];
    assign merged[2*i+1]   = hi_din[i];
  end

  assign lo_cs_n = eng_cs_n | ~lo_sel;
  assign hi_cs_n = eng_cs_n | ~hi_sel;
  assign lo_sclk = eng_sclk & ~lo_cs_n;
  assign hi_sclk = eng_sclk & ~hi_cs_n;

  assign lo_dout = par_mode ? lo_split : eng_dout;
  assign hi_dout = par_mode ? hi_split : eng_dout;
  assign lo_doe  = lo_cs_n ? '0 : eng_doe;
  assign hi_doe  = hi_cs_n ? '0 : eng_doe;

  assign eng_din     = (hi_sel & ~par_mode) ? hi_din : lo_din;
  assign eng_byte_in = par_mode ? merged : '0;

  // R3
  stacked_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (two_dev && !sep_bus) |-> (lo_cs_n || hi_cs_n));

  // R5
  par_cs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode |-> (lo_cs_n == eng_cs_n && hi_cs_n == eng_cs_n));

  // R2
  single_hi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !two_dev |-> (hi_cs_n && !hi_sclk && hi_doe == '0));

  // R9
  clk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lo_cs_n |-> !lo_sclk) and (hi_cs_n |-> !hi_sclk)));

  // R4
  idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (two_dev && !sep_bus && !eng_cs_n) |-> (lo_cs_n ? lo_doe == '0 : hi_doe == '0));

  // R11
  cs_high_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cs_n |-> (lo_cs_n && hi_cs_n && lo_doe == '0 && hi_doe == '0));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!eng_cs_n) |-> $stable(act_q));
endmodule

// File: tb/tb_qspi_dual_router.sv
module tb_qspi_dual_router;
  localparam int PERIOD = 10;
  localparam int NV = 9;

  logic clk = 0, rst_n = 0, cfg_wr = 0;
  logic [31:0] cfg_wdata = '0;
  logic eng_sclk = 1, eng_cs_n = 0;
  logic [3:0] eng_dout = '0, eng_doe = '0, lo_din = '0, hi_din = '0;
  logic [7:0] eng_byte_out = '0;
  logic [3:0] eng_din, lo_dout, lo_doe, hi_dout, hi_doe;
  logic [7:0] eng_byte_in;
  logic lo_cs_n, lo_sclk, hi_cs_n, hi_sclk;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  qspi_dual_router dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .eng_sclk(eng_sclk), .eng_cs_n(eng_cs_n), .eng_dout(eng_dout), .eng_doe(eng_doe),
    .eng_byte_out(eng_byte_out), .eng_din(eng_din), .eng_byte_in(eng_byte_in),
    .lo_cs_n(lo_cs_n), .lo_sclk(lo_sclk), .lo_dout(lo_dout), .lo_doe(lo_doe), .lo_din(lo_din),
    .hi_cs_n(hi_cs_n), .hi_sclk(hi_sclk), .hi_dout(hi_dout), .hi_doe(hi_doe), .hi_din(hi_din));

  // stimulus {mode(two,sep,page), cs_n, sclk, dout, doe, byte, lo_din, hi_din}
  // expected {lo_cs_n,hi_cs_n,lo_sclk,hi_sclk, lo_dout, hi_dout, lo_doe, hi_doe, eng_din, byte_in}
  localparam logic [60:0] VEC [NV] = '{
    {3'b000,1'b0,1'b1,4'hA,4'hF,8'h00,4'h5,4'hC, 4'b0110,4'hA,4'hA,4'hF,4'h0,4'h5,8'h00},
    {3'b001,1'b0,1'b1,4'h3,4'h1,8'h00,4'h5,4'hC, 4'b0110,4'h3,4'h3,4'h1,4'h0,4'h5,8'h00},
    {3'b010,1'b0,1'b1,4'h6,4'hF,8'h00,4'h9,4'h2, 4'b0110,4'h6,4'h6,4'hF,4'h0,4'h9,8'h00},
    {3'b100,1'b0,1'b1,4'hC,4'hF,8'h00,4'h1,4'hE, 4'b0110,4'hC,4'hC,4'hF,4'h0,4'h1,8'h00},
    {3'b101,1'b0,1'b1,4'hC,4'hF,8'h00,4'h1,4'hE, 4'b1001,4'hC,4'hC,4'h0,4'hF,4'hE,8'h00},
    {3'b110,1'b0,1'b1,4'h0,4'hF,8'hB4,4'hA,4'h5, 4'b0011,4'h6,4'hC,4'hF,4'hF,4'hA,8'h66},
    {3'b111,1'b0,1'b1,4'h0,4'hF,8'h55,4'h3,4'hC, 4'b0011,4'hF,4'h0,4'hF,4'hF,4'h3,8'hA5},
    {3'b101,1'b0,1'b0,4'h0,4'h0,8'h00,4'h0,4'h0, 4'b1000,4'h0,4'h0,4'h0,4'h0,4'h0,8'h00},
    {3'b110,1'b1,1'b1,4'h0,4'hF,8'hFF,4'h0,4'h0, 4'b1100,4'hF,4'hF,4'h0,4'h0,4'h0,8'h00}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1, 2: return "R2 single, page/sep ignored, R8";
      3:       return "R3 stacked lower, R8";
      4:       return "R3 R4 stacked upper, R8";
      5:       return "R6 R7 parallel split/merge";
      6:       return "R5 parallel page ignored, R6 R7";
      7:       return "R9 clock low when engine clock low";
      default: return "R11 chip select high";
    endcase
  endfunction

  function automatic logic [31:0] outs();
    return {lo_cs_n, hi_cs_n, lo_sclk, hi_sclk, lo_dout, hi_dout, lo_doe, hi_doe, eng_din, eng_byte_in};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(logic [2:0] m);
    @(negedge clk);
    cfg_wr = 1; cfg_wdata = {1'b0, m, 28'h0};
    @(negedge clk);
    cfg_wr = 0;
  endtask

  initial begin
    #(PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    eng_doe = 4'hF; eng_dout = 4'h9;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1: reset default selects lower device alone
    check("R1 reset default", outs(), {4'b0110, 4'h9, 4'h9, 4'hF, 4'h0, 4'h0, 8'h00});

    for (int i = 0; i < NV; i++) begin
      eng_cs_n = 1;
      write_cfg(VEC[i][60:58]);
      @(negedge clk);
      eng_cs_n = VEC[i][57]; eng_sclk = VEC[i][56]; eng_dout = VEC[i][55:52];
      eng_doe = VEC[i][51:48]; eng_byte_out = VEC[i][47:40];
      lo_din = VEC[i][39:36]; hi_din = VEC[i][35:32];
      #2;
      check(tag_of(i), outs(), VEC[i][31:0]);
    end

    // R10: write during active transfer is deferred
    eng_cs_n = 1; eng_sclk = 1; eng_doe = 4'hF; eng_dout = 4'h0; lo_din = 0; hi_din = 0;
    write_cfg(3'b000);
    @(negedge clk); eng_cs_n = 0;
    write_cfg(3'b101);
    repeat (3) @(negedge clk);
    #1 check("R10 held during transfer", {lo_cs_n, hi_cs_n, 30'h0}, {2'b01, 30'h0});
    eng_cs_n = 1;
    @(negedge clk); eng_cs_n = 0;
    #1 check("R10 applied after chip select high", {lo_cs_n, hi_cs_n, 30'h0}, {2'b10, 30'h0});
    check("R10 R3 upper clock running", {lo_sclk, hi_sclk, 30'h0}, {2'b01, 30'h0});

    // R1: page defaults to lower after reset when two-device mode enabled
    rst_n = 0; eng_cs_n = 1;
    @(negedge clk); rst_n = 1;
    write_cfg(3'b100);
    @(negedge clk); eng_cs_n = 0;
    #1 check("R1 stacked default lower", {lo_cs_n, hi_cs_n, 30'h0}, {2'b01, 30'h0});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule